// File: doc/BRIEF.md
# Profiling Sample Filter

This block sits between the point where a profiling sample is completed and the stage that would encode and store it. Each sample comes in on a valid/ready port. A sample carries four things: a 64-bit vector of the events it hit, five operation-type flags, the total latency measured since sampling began on that instruction, and a 16-bit data-source identifier. Configuration inputs set five independent filters:

- an event filter made of a required-event mask and a forbidden-event mask,
- an operation-type filter whose per-type select bits can each be moved from an OR group into an AND group,
- a minimum-latency threshold,
- a 64-bit data-source mask,
- a discard switch.

A sample is kept only when every filter agrees. The decision is registered, so its effects appear one cycle after the sample is accepted. A kept sample produces a one-cycle match pulse for an event counter. It is also placed in the output register, unless discard is set, in which case only the pulse is produced. The input stalls only while a held output is not taken.

Top module: `sample_filter`

## Requirements
- R1: After reset, out_valid and match_pulse are 0 and in_ready is 1.
- R2: Every bit set in cfg_ev_need must also be set in in_events, or the sample is dropped. Event positions: bit 1 is retired, bit 3 is L1D refill, bit 5 is TLB refill, bit 7 is mispredict. For example, cfg_ev_need = 0x80 keeps only mispredicted samples.
- R3: A sample is dropped if any bit set in cfg_ev_block is also set in in_events. This holds even when the same bit is also set in cfg_ev_need.
- R4: The operation-type flags use bit 0 = branch, 1 = load, 2 = store, 3 = SIMD, 4 = float. Select bits whose cfg_op_and bit is 0 form an OR group: at least one selected type must be present. An empty group passes.
- R5: Select bits whose cfg_op_and bit is 1 form an AND group: every such type must be present. An empty group passes. The operation stage passes only when both groups pass.
- R6: A sample passes the latency filter only when in_latency >= cfg_min_lat.
- R7: When cfg_src_mask is zero, every data source passes. Otherwise a sample passes only if in_src is below 64 and bit in_src of the mask is set.
- R8: With cfg_discard = 1, a kept sample still raises match_pulse but out_valid stays 0.
- R9: A sample accepted at clock edge N shows its decision at edge N+1. match_pulse is 1 for exactly that cycle when the sample is kept. When discard is off, out_valid rises and the sample's fields appear on the out_* ports. A dropped sample raises neither signal.
- R10: in_ready is 0 only while out_valid = 1 and out_ready = 0. While that holds, the output fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted this cycle when high with in_valid |
| in_events | input | 64 | Event vector of the sample |
| in_optype | input | 5 | Operation-type flags |
| in_latency | input | 16 | Total latency count |
| in_src | input | 16 | Data-source identifier |
| cfg_ev_need | input | 64 | Events that must all be present |
| cfg_ev_block | input | 64 | Events of which none may be present |
| cfg_op_sel | input | 5 | Operation types selected |
| cfg_op_and | input | 5 | Per-type AND-group membership |
| cfg_min_lat | input | 16 | Minimum latency |
| cfg_src_mask | input | 64 | One bit per accepted data source, zero disables |
| cfg_discard | input | 1 | Count matches without forwarding |
| out_valid | output | 1 | Kept sample valid |
| out_ready | input | 1 | Downstream takes the sample |
| out_events | output | 64 | Kept sample event vector |
| out_optype | output | 5 | Kept sample operation flags |
| out_latency | output | 16 | Kept sample latency |
| out_src | output | 16 | Kept sample data source |
| match_pulse | output | 1 | One-cycle pulse per kept sample |

## Verification
All filtering is combinational ahead of a single register stage. A wrong filter decision therefore shows at match_pulse and out_valid exactly one edge after the sample is accepted; there is no earlier or later point at which it can hide. A corrupted output register shows as changing out_* fields while backpressure holds. A wrong ready computation shows either as a lost sample or as a duplicated one. The sweeps cover the operation-type filter exhaustively over all select, mode and flag values, and the event filter over all combinations on four event positions, so every group and priority corner is observed.

// File: rtl/sf_pkg.sv
package sf_pkg;
  localparam int OP_N      = 5;
  localparam int OP_BRANCH = 0;
  localparam int OP_LOAD   = 1;
  localparam int OP_STORE  = 2;
  localparam int OP_SIMD   = 3;
  localparam int OP_FLOAT  = 4;
  localparam int SRC_SLOTS = 64;
endpackage

// File: rtl/sf_event_match.sv
module sf_event_match #(
  parameter int EVW = 64
) (
  input  logic [EVW-1:0] events,
  input  logic [EVW-1:0] need,
  input  logic [EVW-1:0] block,
  output logic           ok
);
  function automatic logic ev_ok(input logic [EVW-1:0] ev, input logic [EVW-1:0] nd,
                                 input logic [EVW-1:0] bl);
    logic have_all, hit_block;
    have_all  = ((nd & ~ev) == '0);
    hit_block = |(bl & ev);
    return have_all && !hit_block;
  endfunction

  assign ok = ev_ok(events, need, block);
endmodule

// File: rtl/sf_optype_match.sv
module sf_optype_match #(
  parameter int OPN = sf_pkg::OP_N
) (
  input  logic [OPN-1:0] flags,
  input  logic [OPN-1:0] sel,
  input  logic [OPN-1:0] and_mode,
  output logic           ok
);
  logic [OPN-1:0] or_grp, and_grp;
  logic           or_ok, and_ok;

  function automatic logic grp_any(input logic [OPN-1:0] grp, input logic [OPN-1:0] f);
    return (grp == '0) || (|(grp & f));
  endfunction

  function automatic logic grp_all(input logic [OPN-1:0] grp, input logic [OPN-1:0] f);
    return ((grp & ~f) == '0);
  endfunction

  assign or_grp  = sel & ~and_mode;
  assign and_grp = sel & and_mode;
  assign or_ok   = grp_any(or_grp, flags);
  assign and_ok  = grp_all(and_grp, flags);
  assign ok      = or_ok && and_ok;
endmodule

// File: rtl/sf_source_match.sv
module sf_source_match #(
  parameter int SRCW  = 16,
  parameter int NSRC  = sf_pkg::SRC_SLOTS
) (
  input  logic [SRCW-1:0] src,
  input  logic [NSRC-1:0] mask,
  output logic            ok
);
  localparam int SELW = $clog2(NSRC);

  logic in_range;
  logic bit_hit;

  assign in_range = (32'(src) < NSRC);
  assign bit_hit  = mask[src[SELW-1:0]];
  assign ok       = (mask == '0) || (in_range && bit_hit);
endmodule

// File: rtl/sample_filter.sv
module sample_filter #(
  parameter int EVW  = 64,
  parameter int OPN  = sf_pkg::OP_N,
  parameter int LATW = 16,
  parameter int SRCW = 16,
  parameter int NSRC = sf_pkg::SRC_SLOTS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [EVW-1:0]  in_events,
  input  logic [OPN-1:0]  in_optype,
  input  logic [LATW-1:0] in_latency,
  input  logic [SRCW-1:0] in_src,
  input  logic [EVW-1:0]  cfg_ev_need,
  input  logic [EVW-1:0]  cfg_ev_block,
  input  logic [OPN-1:0]  cfg_op_sel,
  input  logic [OPN-1:0]  cfg_op_and,
  input  logic [LATW-1:0] cfg_min_lat,
  input  logic [NSRC-1:0] cfg_src_mask,
  input  logic            cfg_discard,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [EVW-1:0]  out_events,
  output logic [OPN-1:0]  out_optype,
  output logic [LATW-1:0] out_latency,
  output logic [SRCW-1:0] out_src,
  output logic            match_pulse
);
  logic ev_ok, op_ok, src_ok, lat_ok;
  logic keep_all, take, forward;

  function automatic logic lat_pass(input logic [LATW-1:0] lat, input logic [LATW-1:0] floor_v);
    return lat >= floor_v;
  endfunction

  sf_event_match #(.EVW(EVW)) u_ev (
    .events(in_events), .need(cfg_ev_need), .block(cfg_ev_block), .ok(ev_ok)
  );

  sf_optype_match #(.OPN(OPN)) u_op (
    .flags(in_optype), .sel(cfg_op_sel), .and_mode(cfg_op_and), .ok(op_ok)
  );

  sf_source_match #(.SRCW(SRCW), .NSRC(NSRC)) u_src (
    .src(in_src), .mask(cfg_src_mask), .ok(src_ok)
  );

  assign lat_ok   = lat_pass(in_latency, cfg_min_lat);
  assign keep_all = ev_ok && op_ok && src_ok && lat_ok;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign forward  = take && keep_all && !cfg_discard;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      match_pulse <= 1'b0;
      out_events  <= '0;
      out_optype  <= '0;
      out_latency <= '0;
      out_src     <= '0;
    end else begin
      match_pulse <= take && keep_all;
      if (take)
        out_valid <= forward;
      else if (out_ready)
        out_valid <= 1'b0;
      if (forward) begin
        out_events  <= in_events;
        out_optype  <= in_optype;
        out_latency <= in_latency;
        out_src     <= in_src;
      end
    end
  end
endmodule

// File: rtl/sf_checker.sv
module sf_checker #(
  parameter int EVW  = 64,
  parameter int LATW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [EVW-1:0]  in_events,
  input logic [EVW-1:0]  cfg_ev_block,
  input logic [LATW-1:0] in_latency,
  input logic [LATW-1:0] cfg_min_lat,
  input logic            cfg_discard,
  input logic            keep_all,
  input logic            out_valid,
  input logic            out_ready,
  input logic [EVW-1:0]  out_events,
  input logic            match_pulse
);
  logic accept;
  assign accept = in_valid && in_ready;

  p_pulse_on_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && keep_all |=> match_pulse);

  p_no_pulse_on_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && keep_all) |=> !match_pulse);

  p_block_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (|(in_events & cfg_ev_block)) |=> !match_pulse);

  p_latency_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (in_latency < cfg_min_lat) |=> !match_pulse);

  p_discard_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cfg_discard |=> !out_valid);

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_events));
endmodule

bind sample_filter sf_checker #(.EVW(EVW), .LATW(LATW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_events(in_events), .cfg_ev_block(cfg_ev_block), .in_latency(in_latency),
  .cfg_min_lat(cfg_min_lat), .cfg_discard(cfg_discard), .keep_all(keep_all),
  .out_valid(out_valid), .out_ready(out_ready), .out_events(out_events),
  .match_pulse(match_pulse)
);

// File: tb/sample_filter_test.sv
module sample_filter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_events = '0;
  logic [4:0]  in_optype = '0;
  logic [15:0] in_latency = '0;
  logic [15:0] in_src = '0;
  logic [63:0] cfg_ev_need = '0;
  logic [63:0] cfg_ev_block = '0;
  logic [4:0]  cfg_op_sel = '0;
  logic [4:0]  cfg_op_and = '0;
  logic [15:0] cfg_min_lat = '0;
  logic [63:0] cfg_src_mask = '0;
  logic        cfg_discard = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_events;
  logic [4:0]  out_optype;
  logic [15:0] out_latency;
  logic [15:0] out_src;
  logic        match_pulse;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_filter uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_events(in_events), .in_optype(in_optype), .in_latency(in_latency), .in_src(in_src),
    .cfg_ev_need(cfg_ev_need), .cfg_ev_block(cfg_ev_block), .cfg_op_sel(cfg_op_sel),
    .cfg_op_and(cfg_op_and), .cfg_min_lat(cfg_min_lat), .cfg_src_mask(cfg_src_mask),
    .cfg_discard(cfg_discard), .out_valid(out_valid), .out_ready(out_ready),
    .out_events(out_events), .out_optype(out_optype), .out_latency(out_latency),
    .out_src(out_src), .match_pulse(match_pulse)
  );

  task automatic chk(input bit good, input string req, input longint act, input longint expv);
    tests++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic bit m_ev(input logic [63:0] ev, input logic [63:0] nd, input logic [63:0] bl);
    for (int i = 0; i < 64; i++) begin
      if (nd[i] && !ev[i]) return 0;
      if (bl[i] && ev[i]) return 0;
    end
    return 1;
  endfunction

  function automatic bit m_op(input logic [4:0] f, input logic [4:0] s, input logic [4:0] a);
    int or_n = 0;
    int or_hit = 0;
    for (int i = 0; i < 5; i++) begin
      if (s[i] && a[i] && !f[i]) return 0;
      if (s[i] && !a[i]) begin
        or_n++;
        if (f[i]) or_hit++;
      end
    end
    return (or_n == 0) || (or_hit > 0);
  endfunction

  function automatic bit m_src(input logic [15:0] s, input logic [63:0] m);
    if (m == 64'd0) return 1;
    for (int i = 0; i < 64; i++)
      if (m[i] && s == 16'(i)) return 1;
    return 0;
  endfunction

  function automatic logic [63:0] spread4(input int x);
    logic [63:0] v = '0;
    v[1] = x[0]; v[3] = x[1]; v[5] = x[2]; v[7] = x[3];
    return v;
  endfunction

  task automatic send(input logic [63:0] ev, input logic [4:0] ty, input logic [15:0] lat,
                      input logic [15:0] src, input string req);
    bit k;
    k = m_ev(ev, cfg_ev_need, cfg_ev_block) && m_op(ty, cfg_op_sel, cfg_op_and)
        && (lat >= cfg_min_lat) && m_src(src, cfg_src_mask);
    @(negedge clk);
    in_events = ev; in_optype = ty; in_latency = lat; in_src = src; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(match_pulse == k, {req, " R9 match"}, longint'(match_pulse), longint'(k));
    chk(out_valid == (k && !cfg_discard), {req, " R9 valid"}, longint'(out_valid),
        longint'(k && !cfg_discard));
    if (k && !cfg_discard)
      chk(out_events == ev && out_src == src && out_latency == lat && out_optype == ty,
          {req, " R9 data"}, longint'(out_events), longint'(ev));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 0 && match_pulse == 0 && in_ready == 1, "R1 reset",
        longint'({out_valid, match_pulse, in_ready}), 64'h1);

    // R2 / R3: events on positions 1,3,5,7, all need/block/vector combinations
    for (int n = 0; n < 16; n++)
      for (int b = 0; b < 16; b++)
        for (int e = 0; e < 16; e++) begin
          cfg_ev_need = spread4(n); cfg_ev_block = spread4(b);
          send(spread4(e), 5'd0, 16'd0, 16'd0, ((n & b) != 0) ? "R3" : "R2");
        end
    cfg_ev_need = 64'h80; cfg_ev_block = '0;
    send(64'h80, 5'd0, 16'd0, 16'd0, "R2 mispredict");
    send(64'h0A, 5'd0, 16'd0, 16'd0, "R2 non-mispredict");
    cfg_ev_need = '0;

    // R4 / R5: exhaustive operation-type sweep
    for (int s = 0; s < 32; s++)
      for (int a = 0; a < 32; a++)
        for (int f = 0; f < 32; f++) begin
          cfg_op_sel = 5'(s); cfg_op_and = 5'(a);
          send(64'h2, 5'(f), 16'd0, 16'd0, ((s & a) != 0) ? "R5" : "R4");
        end
    cfg_op_sel = '0; cfg_op_and = '0;

    // R6: latency threshold corners
    for (int t = 0; t < 4; t++)
      for (int l = 0; l < 5; l++) begin
        logic [15:0] tv[4] = '{16'd0, 16'd1, 16'd5, 16'hFFFF};
        logic [15:0] lv[5] = '{16'd0, 16'd4, 16'd5, 16'd6, 16'hFFFF};
        cfg_min_lat = tv[t];
        send(64'h1, 5'd1, lv[l], 16'd0, "R6");
      end
    cfg_min_lat = '0;

    // R7: data-source mask, including ids at and above 64
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 6; i++) begin
        logic [63:0] mv[4] = '{64'd0, 64'h9, 64'h8000_0000_0000_0000, '1};
        logic [15:0] sv[6] = '{16'd0, 16'd3, 16'd5, 16'd63, 16'd64, 16'hFFFF};
        cfg_src_mask = mv[m];
        send(64'h4, 5'd2, 16'd3, sv[i], "R7");
      end
    cfg_src_mask = '0;

    // R8: discard keeps counting, forwards nothing
    cfg_discard = 1'b1;
    send(64'h1, 5'd0, 16'd9, 16'd1, "R8 kept");
    cfg_ev_block = 64'h1;
    send(64'h1, 5'd0, 16'd9, 16'd1, "R8 dropped");
    cfg_ev_block = '0;
    cfg_discard = 1'b0;

    // R10: backpressure holds output and stalls input
    @(negedge clk);
    out_ready = 1'b0;
    in_events = 64'hA; in_optype = 5'd1; in_latency = 16'd7; in_src = 16'd2; in_valid = 1'b1;
    @(negedge clk);
    chk(out_valid == 1 && in_ready == 0, "R10 stall", longint'({out_valid, in_ready}), 64'h2);
    in_events = 64'hB; in_latency = 16'd8;
    repeat (2) @(negedge clk);
    chk(out_events == 64'hA && out_latency == 16'd7 && in_ready == 0, "R10 hold",
        longint'(out_events), 64'hA);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1 && out_events == 64'hB && out_latency == 16'd8, "R10 next",
        longint'(out_events), 64'hB);
    @(negedge clk);
    chk(out_valid == 0 && in_ready == 1, "R10 drain", longint'({out_valid, in_ready}), 64'h1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule